// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital serial side of a telephony voice codec. Each 8 kHz frame it moves one 8-bit companded sample in each direction. On the transmit side the encoder hands a parallel sample in over a valid/ready stream. The block parks it in a one-entry holding buffer. At the next transmit frame-sync rise it shifts the sample out, sign bit first, on `dx`, one bit per rising transmit bit-clock edge. While it drives the line it raises `dx_oe` and pulls the active-low strobe `tsx_n` low.

On the receive side a rising receive frame sync opens a slot. Eight `dr` bits are captured on the following falling edges of the receive bit clock, or of the transmit bit clock when `sync_mode` is high. A fixed number of system-clock cycles after the slot closes, the byte is offered to the decoder on a valid/ready stream. For a programmable interval after reset, the receive output is muted.

All serial pins are asynchronous to `clk`. Each passes through a synchronizer, and its edges are detected in the `clk` domain. `clk` must run at least eight times faster than the fastest bit clock.

Back-pressure rules:
- Transmit: `tx_ready` is high only while the holding buffer is empty. A sample is taken on a cycle where `tx_valid` and `tx_ready` are both high. A sample offered while the buffer is full waits.
- Receive: `rx_valid` stays high, with `rx_data` steady, until a cycle with `rx_ready` high. A later byte that completes its delay before it is taken replaces the unread one.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `dx_oe` is 0, `tsx_n` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rx_mute` is 1.
- R2: A sample is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the next transmit frame-sync rise frees the buffer. A sample offered while the buffer is full is not taken and does not replace the held one.
- R3: The sample held at a transmit frame-sync rise is sent in that slot, most significant bit first. Bit 7 goes out at the first rising transmit bit-clock edge after the frame sync, and each later rising edge sends the next lower bit. If the buffer is empty, IDLE_CODE (default 8'hFF) is sent.
- R4: `dx_oe` goes low at whichever comes later: the falling transmit bit-clock edge after the eighth rising edge, or the fall of the transmit frame sync. This holds for both short and long frame-sync pulses.
- R5: `tsx_n` is low exactly while `dx_oe` is high.
- R6: After a receive frame-sync rise, `dr` is sampled on the next eight falling edges of the receive bit clock. The first bit is bit 7 of `rx_data`.
- R7: With `sync_mode` = 1 the receive slot is clocked by `bclk_tx` and `bclk_rx` is ignored. With `sync_mode` = 0 it is clocked by `bclk_rx`.
- R8: `rx_valid` rises DEC_DELAY system cycles (plus up to five cycles of synchronizer latency) after the eighth falling receive edge, and not earlier.
- R9: `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high. In that cycle `rx_valid` clears.
- R10: For MUTE_CYCLES cycles after reset, `rx_mute` is 1 and `rx_data` shows MUTE_CODE (default 8'hFF). After that, `rx_mute` is 0 for good and `rx_data` shows the received byte.
- R11: A receive frame-sync rise before eight bits have arrived discards the partial byte. No `rx_valid` is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1: receive slot clocked by `bclk_tx` (quasi-static) |
| bclk_tx | input | 1 | Transmit bit clock |
| fs_tx | input | 1 | Transmit frame sync |
| dx | output | 1 | Transmit serial data |
| dx_oe | output | 1 | Tri-state enable for `dx` |
| tsx_n | output | 1 | Active-low transmit time-slot strobe |
| tx_data | input | SAMPLE_W | Encoded sample from the encoder |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding buffer is empty |
| bclk_rx | input | 1 | Receive bit clock (asynchronous mode) |
| fs_rx | input | 1 | Receive frame sync |
| dr | input | 1 | Receive serial data |
| rx_data | output | SAMPLE_W | Received byte for the decoder |
| rx_valid | output | 1 | Decoder update strobe, held until taken |
| rx_ready | input | 1 | Decoder takes `rx_data` |
| rx_mute | output | 1 | Power-up mute active |

## Verification
The vector table sends bytes with alternating bits, a lone sign bit, a lone low bit and their complements. A swapped bit order or a lost shift therefore shows up as a wrong value, not a coincidental match. Each vector pairs short or long frame sync with synchronous or asynchronous clocking. Short pulses show that release follows the eighth falling edge; long pulses show that release waits for the frame sync to fall. In synchronous frames `bclk_rx` is left idle, and a separate receive-only frame leaves `bclk_tx` idle, so the clock selection is pinned in both directions. Directed frames cover the empty buffer (idle code), a second sample offered while the buffer is full, the decoder delay window, a three-bit partial slot and data received under mute.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
  // positions of the raw serial pins in the synchronizer vector
  localparam int PIN_BCLK_TX = 0;
  localparam int PIN_BCLK_RX = 1;
  localparam int PIN_FS_TX   = 2;
  localparam int PIN_FS_RX   = 3;
  localparam int PIN_DR      = 4;
  localparam int PIN_COUNT   = 5;

  // transmit slot phases
  typedef enum logic [1:0] {
    TXS_IDLE  = 2'd0,
    TXS_SHIFT = 2'd1,
    TXS_HOLD  = 2'd2
  } tx_phase_t;
endpackage

// File: rtl/pcm_edge_sync.sv
`timescale 1ns/1ps
module pcm_edge_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_lvl,
  output logic [W-1:0] pin_prv
);
  // one flop chain per pin; the extra last stage gives the previous level
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_raw[g]};
    end
    assign pin_lvl[g] = chain[STAGES-1];
    assign pin_prv[g] = chain[STAGES];
  end
endmodule

// File: rtl/pcm_tx_slot.sv
`timescale 1ns/1ps
module pcm_tx_slot
  import pcm_pkg::*;
#(
  parameter int              SW        = 8,
  parameter logic [SW-1:0]   IDLE_CODE = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          bclk_rise,
  input  logic          bclk_fall,
  input  logic          fs_rise,
  input  logic          fs_lvl,
  output logic          dx,
  output logic          dx_oe
);
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] hold_q;
  logic          hold_full;
  logic [SW-1:0] shift_q;
  logic [CW-1:0] bits_q;
  tx_phase_t     phase_q;
  logic          oe_q;
  logic          take;

  assign in_ready = ~hold_full;
  assign take     = in_valid & ~hold_full;

  // holding buffer: drained by frame sync, filled by the stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (take) hold_q <= in_data;
      hold_full <= (hold_full & ~fs_rise) | take;
    end
  end

  // slot sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
      phase_q <= TXS_IDLE;
      oe_q    <= 1'b0;
    end else if (fs_rise) begin
      shift_q <= hold_full ? hold_q : IDLE_CODE;
      bits_q  <= '0;
      phase_q <= TXS_SHIFT;
      oe_q    <= 1'b0;
    end else begin
      case (phase_q)
        TXS_SHIFT: begin
          if (bclk_rise && bits_q != CW'(SW)) begin
            if (bits_q != '0) shift_q <= {shift_q[SW-2:0], 1'b0};
            oe_q   <= 1'b1;
            bits_q <= bits_q + 1'b1;
          end
          if (bclk_fall && bits_q == CW'(SW)) phase_q <= TXS_HOLD;
        end
        TXS_HOLD: begin
          if (!fs_lvl) begin
            oe_q    <= 1'b0;
            phase_q <= TXS_IDLE;
          end
        end
        default: phase_q <= TXS_IDLE;
      endcase
    end
  end

  assign dx    = oe_q & shift_q[SW-1];
  assign dx_oe = oe_q;
endmodule

// File: rtl/pcm_rx_slot.sv
`timescale 1ns/1ps
module pcm_rx_slot #(
  parameter int SW        = 8,
  parameter int DEC_DELAY = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_fall,
  input  logic          fs_rise,
  input  logic          dr_lvl,
  output logic [SW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready
);
  localparam int RCW = $clog2(SW);
  localparam int DW  = $clog2(DEC_DELAY + 1);

  logic [SW-1:0]  shift_q;
  logic [RCW-1:0] bits_q;
  logic           open_q;
  logic           slot_end;
  logic [SW-1:0]  byte_now;
  logic [SW-1:0]  pend_q;
  logic [DW-1:0]  wait_q;
  logic           fire;
  logic [SW-1:0]  data_q;
  logic           valid_q;

  assign byte_now = {shift_q[SW-2:0], dr_lvl};
  assign slot_end = open_q & ~fs_rise & bclk_fall & (bits_q == RCW'(SW - 1));

  // capture: frame sync restarts the slot and discards partial bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
      open_q  <= 1'b0;
    end else if (fs_rise) begin
      bits_q <= '0;
      open_q <= 1'b1;
    end else if (open_q && bclk_fall) begin
      shift_q <= byte_now;
      bits_q  <= bits_q + 1'b1;
      if (bits_q == RCW'(SW - 1)) open_q <= 1'b0;
    end
  end

  // decoder update timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wait_q <= '0;
    end else if (slot_end) begin
      pend_q <= byte_now;
      wait_q <= DW'(DEC_DELAY);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end
  assign fire = ~slot_end & (wait_q == DW'(1));

  // output stage with hold-until-taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (fire) begin
      data_q  <= pend_q;
      valid_q <= 1'b1;
    end else if (valid_q && out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/pcm_mute_timer.sv
`timescale 1ns/1ps
module pcm_mute_timer #(
  parameter int MUTE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  output logic muted
);
  localparam int MW = $clog2(MUTE_CYCLES + 1);
  logic [MW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (cnt_q != MW'(MUTE_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end
  assign muted = (cnt_q != MW'(MUTE_CYCLES));
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
  import pcm_pkg::*;
#(
  parameter int                  SAMPLE_W    = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  DEC_DELAY   = 500,
  parameter int                  MUTE_CYCLES = 500000,
  parameter logic [SAMPLE_W-1:0] IDLE_CODE   = '1,
  parameter logic [SAMPLE_W-1:0] MUTE_CODE   = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_mode,
  input  logic                bclk_tx,
  input  logic                fs_tx,
  output logic                dx,
  output logic                dx_oe,
  output logic                tsx_n,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic                bclk_rx,
  input  logic                fs_rx,
  input  logic                dr,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                rx_mute
);
  logic [PIN_COUNT-1:0] pin_raw;
  logic [PIN_COUNT-1:0] pin_lvl;
  logic [PIN_COUNT-1:0] pin_prv;

  assign pin_raw[PIN_BCLK_TX] = bclk_tx;
  assign pin_raw[PIN_BCLK_RX] = bclk_rx;
  assign pin_raw[PIN_FS_TX]   = fs_tx;
  assign pin_raw[PIN_FS_RX]   = fs_rx;
  assign pin_raw[PIN_DR]      = dr;

  pcm_edge_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_raw),
    .pin_lvl (pin_lvl),
    .pin_prv (pin_prv)
  );

  logic tx_bclk_rise, tx_bclk_fall, tx_fs_rise, tx_fs_lvl;
  logic rx_bclk_fall, rx_fs_rise;
  logic unused_dr_prev;

  assign tx_bclk_rise   =  pin_lvl[PIN_BCLK_TX] & ~pin_prv[PIN_BCLK_TX];
  assign tx_bclk_fall   = ~pin_lvl[PIN_BCLK_TX] &  pin_prv[PIN_BCLK_TX];
  assign tx_fs_rise     =  pin_lvl[PIN_FS_TX]   & ~pin_prv[PIN_FS_TX];
  assign tx_fs_lvl      =  pin_lvl[PIN_FS_TX];
  assign rx_fs_rise     =  pin_lvl[PIN_FS_RX]   & ~pin_prv[PIN_FS_RX];
  assign rx_bclk_fall   = sync_mode ? tx_bclk_fall
                                    : (~pin_lvl[PIN_BCLK_RX] & pin_prv[PIN_BCLK_RX]);
  assign unused_dr_prev = pin_prv[PIN_DR];

  pcm_tx_slot #(.SW(SAMPLE_W), .IDLE_CODE(IDLE_CODE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (tx_data),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .bclk_rise (tx_bclk_rise),
    .bclk_fall (tx_bclk_fall),
    .fs_rise   (tx_fs_rise),
    .fs_lvl    (tx_fs_lvl),
    .dx        (dx),
    .dx_oe     (dx_oe)
  );
  assign tsx_n = ~dx_oe;

  logic [SAMPLE_W-1:0] rx_byte;
  pcm_rx_slot #(.SW(SAMPLE_W), .DEC_DELAY(DEC_DELAY)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_fall (rx_bclk_fall),
    .fs_rise   (rx_fs_rise),
    .dr_lvl    (pin_lvl[PIN_DR]),
    .out_data  (rx_byte),
    .out_valid (rx_valid),
    .out_ready (rx_ready)
  );

  pcm_mute_timer #(.MUTE_CYCLES(MUTE_CYCLES)) u_mute (
    .clk   (clk),
    .rst_n (rst_n),
    .muted (rx_mute)
  );
  assign rx_data = rx_mute ? MUTE_CODE : rx_byte;
endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dx_oe,
  input logic tx_bclk_rise,
  input logic tx_fs_rise,
  input logic tx_fs_lvl,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_mute
);
  // R3
  oe_rise_on_bclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(tx_bclk_rise));

  // R4
  oe_release_fs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dx_oe) |-> (!$past(tx_fs_lvl) || $past(tx_fs_rise)));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R10
  mute_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mute |=> !rx_mute);
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dx_oe        (dx_oe),
  .tx_bclk_rise (tx_bclk_rise),
  .tx_fs_rise   (tx_fs_rise),
  .tx_fs_lvl    (tx_fs_lvl),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_mute      (rx_mute)
);

// File: tb/pcm_slot_port_bench.sv
`timescale 1ns/1ps
module pcm_slot_port_bench;
  localparam int DEC = 40;
  localparam int MUTE = 600;
  localparam int HB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic bclk_tx = 1'b0, fs_tx = 1'b0, bclk_rx = 1'b0, fs_rx = 1'b0, dr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic dx, dx_oe, tsx_n, tx_ready, rx_valid, rx_mute;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  pcm_slot_port #(.DEC_DELAY(DEC), .MUTE_CYCLES(MUTE)) u_pcm_slot_port (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .bclk_tx(bclk_tx), .fs_tx(fs_tx), .dx(dx), .dx_oe(dx_oe), .tsx_n(tsx_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .bclk_rx(bclk_rx), .fs_rx(fs_rx), .dr(dr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_mute(rx_mute)
  );

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  typedef struct packed {
    logic [7:0] txb;
    logic [7:0] rxb;
    logic       syn;
    logic       lng;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{8'hA5, 8'h3C, 1'b1, 1'b0},
    '{8'h5A, 8'hC3, 1'b1, 1'b1},
    '{8'h80, 8'h01, 1'b0, 1'b0},
    '{8'h7F, 8'hFE, 1'b0, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input int hold);
    tx_data  = b;
    tx_valid = 1'b1;
    tick(hold);
    tx_valid = 1'b0;
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
    chk("R9 rx_valid after take", rx_valid, 0);
  endtask

  // full frame on both directions
  task automatic run_frame(input logic [7:0] txexp, input logic [7:0] rxb,
                           input logic syn, input logic lng);
    sync_mode = syn;
    fs_tx = 1'b1;
    fs_rx = 1'b1;
    tick(HB);
    for (int i = 0; i < 8; i++) begin
      bclk_tx = 1'b1;
      if (!syn) bclk_rx = 1'b1;
      dr = rxb[7-i];
      tick(HB);
      chk("R3 dx bit", dx, txexp[7-i]);
      if (i == 0) begin
        chk("R4 dx_oe in slot", dx_oe, 1);
        chk("R5 tsx_n in slot", tsx_n, 0);
      end
      bclk_tx = 1'b0;
      bclk_rx = 1'b0;
      if (i == 0 && !lng) begin
        fs_tx = 1'b0;
        fs_rx = 1'b0;
      end
      tick(HB);
    end
    if (lng) begin
      chk("R4 dx_oe held by long frame sync", dx_oe, 1);
      fs_tx = 1'b0;
      fs_rx = 1'b0;
      tick(8);
    end
    chk("R4 dx_oe released", dx_oe, 0);
    chk("R5 tsx_n released", tsx_n, 1);
    tick(DEC + 15);
    chk(syn ? "R7 rx_valid sync clocking" : "R6 rx_valid", rx_valid, 1);
    chk(syn ? "R7 rx_data sync clocking" : "R6 rx_data", rx_data, rxb);
    take_rx();
  endtask

  // receive-only slot on bclk_rx, nbits bits
  task automatic rx_only(input logic [7:0] b, input int nbits);
    fs_rx = 1'b1;
    tick(HB);
    for (int i = 0; i < nbits; i++) begin
      bclk_rx = 1'b1;
      dr = b[7-i];
      tick(HB);
      bclk_rx = 1'b0;
      if (i == 0) fs_rx = 1'b0;
      tick(HB);
    end
    fs_rx = 1'b0;
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 dx_oe", dx_oe, 0);
    chk("R1 tsx_n", tsx_n, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_mute", rx_mute, 1);

    // R10 data under mute, async receive with bclk_tx idle (R7)
    sync_mode = 1'b0;
    rx_only(8'h3C, 8);
    tick(DEC + 15);
    chk("R7 rx_valid from bclk_rx", rx_valid, 1);
    chk("R10 rx_data muted", rx_data, 8'hFF);
    chk("R10 rx_mute early", rx_mute, 1);
    tick(5);
    chk("R9 rx_valid held", rx_valid, 1);
    tick(MUTE);
    chk("R10 rx_mute cleared", rx_mute, 0);
    chk("R10 rx_data after mute", rx_data, 8'h3C);
    take_rx();

    // vector table
    for (int v = 0; v < 4; v++) begin
      push(VECS[v].txb, 1);
      chk("R2 tx_ready after accept", tx_ready, 0);
      run_frame(VECS[v].txb, VECS[v].rxb, VECS[v].syn, VECS[v].lng);
      chk("R2 tx_ready after frame sync", tx_ready, 1);
    end

    // R3 empty buffer sends idle code
    run_frame(8'hFF, 8'h69, 1'b0, 1'b0);

    // R2 second sample while full is not taken
    push(8'h96, 1);
    push(8'h0F, 3);
    chk("R2 tx_ready while full", tx_ready, 0);
    run_frame(8'h96, 8'h55, 1'b1, 1'b0);
    run_frame(8'hFF, 8'hAA, 1'b1, 1'b0);

    // R8 decoder delay window
    sync_mode = 1'b0;
    rx_only(8'hB2, 8);
    tick(20);
    chk("R8 rx_valid too early", rx_valid, 0);
    tick(15);
    chk("R8 rx_valid on time", rx_valid, 1);
    chk("R8 rx_data", rx_data, 8'hB2);
    take_rx();

    // R11 partial slot discarded
    rx_only(8'hF0, 3);
    tick(DEC + 30);
    chk("R11 no strobe for partial", rx_valid, 0);
    rx_only(8'h5A, 8);
    tick(DEC + 15);
    chk("R11 rx_valid after full slot", rx_valid, 1);
    chk("R11 rx_data after full slot", rx_data, 8'h5A);
    take_rx();

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule